// File: doc/BRIEF.md
# ATA Drive Position Signature Probe

This block finds out what is attached at one drive position of a parallel taskfile register bus. On a start pulse it selects the device, reads the four signature registers and chooses between the packet-device identify command and the plain disk identify command. It then polls the status register until the device stops reporting busy or a poll budget runs out. The budget is larger for packet devices. If the final status does not show data ready, the block selects the device again, waits, issues a device soft reset and tries once more.

The result comes out with a one-cycle done pulse: whether a device answered, and whether it is a packet device. When a device answered, a companion one-cycle pulse tells a downstream data engine to read the 256-word identify block from the data register. Parsing that block, the bus-wide hardware reset and power management are handled elsewhere. The taskfile side is a plain request/acknowledge register port with no data streaming, and every pin is a plain control or status signal.

Top module: `ata_probe`

## Requirements
- R1: Out of reset, busy, done, present, is_atapi, id_fetch and tf_cs are all 0.
- R2: A probe starts with a write to the device/head register (address 6) of 0xE0 with bit 4 set to dev_sel. No signature register is read before that write.
- R3: The signature registers are read at addresses 2, 3, 4 and 5. Only when they hold 0x01, 0x01, 0x14 and 0xEB at the same time is 0xA1 written to the command register (address 7). Any other combination writes 0xEC.
- R4: After the command, the status register (address 7) is read repeatedly, with more than POLL_GAP idle cycles between reads. Polling stops at the first read with bit 7 (busy) clear. Otherwise it stops after ATA_POLLS reads for the 0xEC command, or after ATAPI_POLLS reads for 0xA1.
- R5: An attempt succeeds when the last status read has bit 3 (data request) set and both bit 5 (device fault) and bit 0 (error) clear.
- R6: After a failed first attempt, the block performs these steps in order. It writes the device/head value again, waits at least SETTLE_CYC cycles, and writes 0x08 to address 7. It then waits at least RESET_CYC cycles, writes the device/head value again, and repeats the signature check and identify from the start.
- R7: After a failed second attempt, the block reports present=0 and is_atapi=0. At most one 0x08 is written per probe.
- R8: done is a single-cycle pulse. present and is_atapi are valid with it and hold until the next start, and is_atapi=1 only when present=1. id_fetch pulses exactly with done when present=1 and never otherwise.
- R9: A start pulse while busy=1 is ignored: it causes no extra command and no extra done pulse.
- R10: A taskfile request (tf_cs=1) keeps tf_we, tf_addr and tf_wdata stable until the cycle tf_ack is seen. The access completes in that cycle, and read data is taken from tf_rdata in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| dev_sel | input | 1 | Drive position number placed in device/head bit 4 |
| tf_cs | output | 1 | Taskfile access request |
| tf_we | output | 1 | 1 = write, 0 = read |
| tf_addr | output | 3 | Taskfile register address |
| tf_wdata | output | 8 | Write data |
| tf_ack | input | 1 | Access complete |
| tf_rdata | input | 8 | Read data, valid with tf_ack |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle result pulse |
| present | output | 1 | A device answered identify |
| is_atapi | output | 1 | The device answered as a packet device |
| id_fetch | output | 1 | Pulse: read the identify block now |

## Verification
A wrong signature latch or a wrong comparison shows up on the very next command write, as the wrong identify opcode. A miscounted poll budget shows as a wrong number of status reads before the verdict, within one poll budget. A broken attempt flag shows within one retry interval, either as a second 0x08 write or as a verdict that arrives without the retry. Output flags that are stale or inconsistent are visible on the done pulse itself, because present, is_atapi and id_fetch are sampled together there.

// File: rtl/ata_probe_pkg.sv
package ata_probe_pkg;

  localparam logic [2:0] TF_SIG_BASE = 3'd2;
  localparam logic [2:0] TF_DEVHEAD  = 3'd6;
  localparam logic [2:0] TF_CMDSTAT  = 3'd7;

  localparam logic [7:0] OP_IDENT_DISK = 8'hEC;
  localparam logic [7:0] OP_IDENT_PKT  = 8'hA1;
  localparam logic [7:0] OP_SOFT_RESET = 8'h08;
  localparam logic [7:0] DEVHEAD_BASE  = 8'hE0;

  localparam int ST_BUSY  = 7;
  localparam int ST_FAULT = 5;
  localparam int ST_DREQ  = 3;
  localparam int ST_ERROR = 0;

  localparam int SIG_LEN = 4;

  function automatic logic [7:0] pkt_sig_byte(input int idx);
    case (idx)
      0: return 8'h01;
      1: return 8'h01;
      2: return 8'h14;
      default: return 8'hEB;
    endcase
  endfunction

  typedef enum logic [3:0] {
    PS_IDLE, PS_SEL, PS_RD_SIG, PS_CMD, PS_RD_STAT, PS_GAP, PS_EVAL,
    PS_RESEL, PS_W_SETTLE, PS_SRST, PS_W_RST, PS_SEL2
  } probe_state_e;

endpackage

// File: rtl/ata_probe_timer.sv
module ata_probe_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  // A loaded count never rises on its own (supports R4 and R6 waits)
  assert_no_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (cnt <= $past(cnt)));
endmodule

// File: rtl/ata_sig_match.sv
module ata_sig_match
  import ata_probe_pkg::*;
#(
  parameter int N = SIG_LEN
) (
  input  logic [N-1:0][7:0] sig,
  output logic              hit
);
  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = (sig[i] == pkt_sig_byte(i));
  end

  assign hit = &eq;
endmodule

// File: rtl/ata_probe.sv
module ata_probe
  import ata_probe_pkg::*;
#(
  parameter int POLL_GAP    = 10000,
  parameter int ATA_POLLS   = 20000,
  parameter int ATAPI_POLLS = 70000,
  parameter int SETTLE_CYC  = 10000000,
  parameter int RESET_CYC   = 50000000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dev_sel,
  output logic       tf_cs,
  output logic       tf_we,
  output logic [2:0] tf_addr,
  output logic [7:0] tf_wdata,
  input  logic       tf_ack,
  input  logic [7:0] tf_rdata,
  output logic       busy,
  output logic       done,
  output logic       present,
  output logic       is_atapi,
  output logic       id_fetch
);
  localparam int T_MAX0 = (POLL_GAP > SETTLE_CYC) ? POLL_GAP : SETTLE_CYC;
  localparam int T_MAX  = (T_MAX0 > RESET_CYC) ? T_MAX0 : RESET_CYC;
  localparam int TW     = $clog2(T_MAX + 1);
  localparam int P_MAX  = (ATA_POLLS > ATAPI_POLLS) ? ATA_POLLS : ATAPI_POLLS;
  localparam int PW     = $clog2(P_MAX + 1);
  localparam int IW     = $clog2(SIG_LEN);

  probe_state_e              state;
  logic                      dev_q, retry_q, kind_q;
  logic [IW-1:0]             sig_idx;
  logic [SIG_LEN-1:0][7:0]   sig_q;
  logic [7:0]                stat_q;
  logic [PW-1:0]             poll_cnt, poll_last;
  logic                      done_q, present_q, atapi_q, fetch_q;
  logic                      sig_hit, tmr_load, tmr_zero, poll_more, att_ok;
  logic [TW-1:0]             tmr_val;
  logic [7:0]                devhead;

  ata_sig_match #(.N(SIG_LEN)) u_match (.sig(sig_q), .hit(sig_hit));

  ata_probe_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  assign devhead   = DEVHEAD_BASE | {3'b000, dev_q, 4'b0000};
  assign poll_last = kind_q ? PW'(ATAPI_POLLS - 1) : PW'(ATA_POLLS - 1);
  assign poll_more = tf_rdata[ST_BUSY] && (poll_cnt != poll_last);
  assign att_ok    = stat_q[ST_DREQ] && !stat_q[ST_FAULT] && !stat_q[ST_ERROR];

  // Taskfile request decode
  always_comb begin
    tf_cs    = 1'b0;
    tf_we    = 1'b0;
    tf_addr  = TF_CMDSTAT;
    tf_wdata = '0;
    unique case (state)
      PS_SEL, PS_RESEL, PS_SEL2: begin
        tf_cs = 1'b1; tf_we = 1'b1; tf_addr = TF_DEVHEAD; tf_wdata = devhead;
      end
      PS_RD_SIG: begin
        tf_cs = 1'b1; tf_addr = TF_SIG_BASE + {{(3-IW){1'b0}}, sig_idx};
      end
      PS_CMD: begin
        tf_cs = 1'b1; tf_we = 1'b1;
        tf_wdata = sig_hit ? OP_IDENT_PKT : OP_IDENT_DISK;
      end
      PS_RD_STAT: tf_cs = 1'b1;
      PS_SRST: begin
        tf_cs = 1'b1; tf_we = 1'b1; tf_wdata = OP_SOFT_RESET;
      end
      default: ;
    endcase
  end

  // Timer loads
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (tf_ack) begin
      if (state == PS_RD_STAT && poll_more) begin
        tmr_load = 1'b1; tmr_val = TW'(POLL_GAP);
      end else if (state == PS_RESEL) begin
        tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC);
      end else if (state == PS_SRST) begin
        tmr_load = 1'b1; tmr_val = TW'(RESET_CYC);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= PS_IDLE;
      dev_q     <= 1'b0;
      retry_q   <= 1'b0;
      kind_q    <= 1'b0;
      sig_idx   <= '0;
      sig_q     <= '0;
      stat_q    <= '0;
      poll_cnt  <= '0;
      done_q    <= 1'b0;
      present_q <= 1'b0;
      atapi_q   <= 1'b0;
      fetch_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fetch_q <= 1'b0;
      unique case (state)
        PS_IDLE: if (start) begin
          dev_q     <= dev_sel;
          retry_q   <= 1'b0;
          present_q <= 1'b0;
          atapi_q   <= 1'b0;
          state     <= PS_SEL;
        end
        PS_SEL, PS_SEL2: if (tf_ack) begin
          if (state == PS_SEL2) retry_q <= 1'b1;
          sig_idx <= '0;
          state   <= PS_RD_SIG;
        end
        PS_RD_SIG: if (tf_ack) begin
          sig_q[sig_idx] <= tf_rdata;
          if (sig_idx == IW'(SIG_LEN - 1)) state <= PS_CMD;
          else sig_idx <= sig_idx + 1'b1;
        end
        PS_CMD: if (tf_ack) begin
          kind_q   <= sig_hit;
          poll_cnt <= '0;
          state    <= PS_RD_STAT;
        end
        PS_RD_STAT: if (tf_ack) begin
          stat_q <= tf_rdata;
          if (poll_more) begin
            poll_cnt <= poll_cnt + 1'b1;
            state    <= PS_GAP;
          end else begin
            state <= PS_EVAL;
          end
        end
        PS_GAP: if (tmr_zero) state <= PS_RD_STAT;
        PS_EVAL: begin
          if (att_ok) begin
            done_q <= 1'b1; present_q <= 1'b1; atapi_q <= kind_q; fetch_q <= 1'b1;
            state  <= PS_IDLE;
          end else if (retry_q) begin
            done_q <= 1'b1; present_q <= 1'b0; atapi_q <= 1'b0;
            state  <= PS_IDLE;
          end else begin
            state <= PS_RESEL;
          end
        end
        PS_RESEL:    if (tf_ack) state <= PS_W_SETTLE;
        PS_W_SETTLE: if (tmr_zero) state <= PS_SRST;
        PS_SRST:     if (tf_ack) state <= PS_W_RST;
        PS_W_RST:    if (tmr_zero) state <= PS_SEL2;
        default:     state <= PS_IDLE;
      endcase
    end
  end

  assign busy     = (state != PS_IDLE);
  assign done     = done_q;
  assign present  = present_q;
  assign is_atapi = atapi_q;
  assign id_fetch = fetch_q;

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_cs && !tf_ack) |=> (tf_cs && $stable(tf_we) && $stable(tf_addr) && $stable(tf_wdata)));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_fetch_only_present_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id_fetch |-> (done && present));
  assert_absent_not_pkt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !present) |-> !is_atapi);
  assert_single_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_cs && tf_we && tf_addr == TF_CMDSTAT && tf_wdata == OP_SOFT_RESET) |-> !retry_q);
  assert_idle_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/ata_probe_bench.sv
module ata_probe_bench;
  localparam int GAP = 2, NPA = 4, NPP = 6, SET = 20, RST = 30;

  logic clk = 0, rst_n = 0, start = 0, dev_sel = 0;
  logic tf_cs, tf_we, tf_ack, busy, done, present, is_atapi, id_fetch;
  logic [2:0] tf_addr;
  logic [7:0] tf_wdata, tf_rdata;

  always #5 clk = ~clk;

  ata_probe #(.POLL_GAP(GAP), .ATA_POLLS(NPA), .ATAPI_POLLS(NPP),
              .SETTLE_CYC(SET), .RESET_CYC(RST)) u_ata_probe (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_sel(dev_sel),
    .tf_cs(tf_cs), .tf_we(tf_we), .tf_addr(tf_addr), .tf_wdata(tf_wdata),
    .tf_ack(tf_ack), .tf_rdata(tf_rdata), .busy(busy), .done(done),
    .present(present), .is_atapi(is_atapi), .id_fetch(id_fetch));

  int n_chk = 0, n_fail = 0;

  // device model configuration (written only by the stimulus process)
  logic [7:0] sig_cfg [4];
  int out_cfg [2];
  int busy_n = 0;
  logic clr = 0;

  // device model state
  logic ack_q = 0;
  logic [7:0] rd_q = 0;
  int cyc = 0, stat_reads = 0, rst_cnt = 0, cmd_cnt = 0, done_cnt = 0, fetch_cnt = 0;
  int min_gap = 0, t_stat = 0, t_dh = 0, t_rst = 0, settle_gap = 0, reset_gap = 0, dh_cnt = 0;
  logic [7:0] cmd_last = 0, dh_last = 0;
  logic early_sig = 0;

  assign tf_ack = ack_q;
  assign tf_rdata = rd_q;

  function automatic logic [7:0] status_for(int att, int r);
    int o;
    o = out_cfg[att > 1 ? 1 : att];
    if (o == 4) return 8'h80;
    if (r < busy_n) return 8'h80;
    case (o)
      0: return 8'h48;
      1: return 8'h49;
      2: return 8'h68;
      default: return 8'h40;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clr) begin
      stat_reads <= 0; rst_cnt <= 0; cmd_cnt <= 0; done_cnt <= 0; fetch_cnt <= 0;
      min_gap <= 1000000; settle_gap <= 0; reset_gap <= 0; dh_cnt <= 0;
      early_sig <= 0; ack_q <= 0;
    end else begin
      if (done) done_cnt <= done_cnt + 1;
      if (id_fetch) fetch_cnt <= fetch_cnt + 1;
      if (tf_cs && !ack_q) begin
        ack_q <= 1;
        if (tf_we) begin
          if (tf_addr == 3'd6) begin
            dh_last <= tf_wdata; dh_cnt <= dh_cnt + 1; t_dh <= cyc;
            if (rst_cnt > 0) reset_gap <= cyc - t_rst;
          end else if (tf_addr == 3'd7) begin
            if (tf_wdata == 8'h08) begin
              rst_cnt <= rst_cnt + 1; t_rst <= cyc; settle_gap <= cyc - t_dh;
            end else begin
              cmd_last <= tf_wdata; cmd_cnt <= cmd_cnt + 1; stat_reads <= 0;
            end
          end
        end else begin
          if (tf_addr >= 3'd2 && tf_addr <= 3'd5) begin
            rd_q <= sig_cfg[tf_addr - 3'd2];
            if (dh_cnt == 0) early_sig <= 1;
          end else if (tf_addr == 3'd7) begin
            rd_q <= status_for(rst_cnt, stat_reads);
            if (stat_reads > 0 && (cyc - t_stat) < min_gap) min_gap <= cyc - t_stat;
            stat_reads <= stat_reads + 1; t_stat <= cyc;
          end else rd_q <= 8'h00;
        end
      end else ack_q <= 0;
    end
  end

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_sig(input int s);
    sig_cfg[0] = 8'h01; sig_cfg[1] = 8'h01; sig_cfg[2] = 8'h14; sig_cfg[3] = 8'hEB;
    if (s >= 1 && s <= 4) sig_cfg[s-1] = sig_cfg[s-1] ^ 8'h01;
    if (s == 5) begin sig_cfg[0]=8'h01; sig_cfg[1]=8'h01; sig_cfg[2]=8'h00; sig_cfg[3]=8'h00; end
  endtask

  task automatic run_one(input int s, input int o0, input int o1, input int dv, input int bn);
    logic hit, exp_pres;
    int att_final, o_fin, lim, exp_reads;
    @(negedge clk);
    set_sig(s); out_cfg[0] = o0; out_cfg[1] = o1; busy_n = bn; dev_sel = dv[0];
    clr = 1;
    @(negedge clk);
    clr = 0; start = 1;
    @(negedge clk);
    start = 0;
    while (done_cnt == 0) @(negedge clk);
    @(negedge clk);
    hit = (s == 0);
    lim = hit ? NPP : NPA;
    exp_pres = (o0 == 0) || (o1 == 0);
    att_final = (o0 == 0) ? 0 : 1;
    o_fin = (att_final == 0) ? o0 : o1;
    exp_reads = (o_fin == 4) ? lim : bn + 1;
    chk(dh_last == (8'hE0 | (8'(dv) << 4)), "R2 devhead", dh_last, 8'hE0 | (dv << 4));
    chk(!early_sig, "R2 select before signature", early_sig, 0);
    chk(cmd_last == (hit ? 8'hA1 : 8'hEC), "R3 opcode", cmd_last, hit ? 8'hA1 : 8'hEC);
    chk(stat_reads == exp_reads, "R4 status reads", stat_reads, exp_reads);
    if (exp_reads > 1) chk(min_gap > GAP, "R4 poll gap", min_gap, GAP + 1);
    chk(present == exp_pres, "R5 present", present, exp_pres);
    chk(rst_cnt == att_final, "R6 soft reset count", rst_cnt, att_final);
    chk(cmd_cnt == att_final + 1, "R7 attempts", cmd_cnt, att_final + 1);
    if (att_final == 1) begin
      chk(settle_gap >= SET, "R6 settle wait", settle_gap, SET);
      chk(reset_gap >= RST, "R6 reset wait", reset_gap, RST);
      chk(dh_cnt == 3, "R6 reselects", dh_cnt, 3);
    end
    chk(is_atapi == (exp_pres && hit), "R8 is_atapi", is_atapi, exp_pres && hit);
    chk(fetch_cnt == (exp_pres ? 1 : 0), "R8 id_fetch", fetch_cnt, exp_pres ? 1 : 0);
    chk(done_cnt == 1, "R8 single done", done_cnt, 1);
    chk(!busy, "R9 idle after done", busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int k;
    set_sig(0); out_cfg[0] = 0; out_cfg[1] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !present && !is_atapi && !id_fetch && !tf_cs, "R1 reset outputs",
        {busy, done, present, is_atapi, id_fetch, tf_cs}, 0);
    rst_n = 1;
    k = 0;
    for (int s = 0; s < 6; s++)
      for (int o0 = 0; o0 < 5; o0++)
        for (int o1 = 0; o1 < 5; o1++) begin
          if (o0 == 0 && o1 > 0) continue;
          run_one(s, o0, o1, k % 2, k % 3);
          k++;
        end
    // R9: start while busy is ignored; R10 is guarded by the handshake in the model
    @(negedge clk);
    set_sig(0); out_cfg[0] = 0; out_cfg[1] = 0; busy_n = 2; clr = 1;
    @(negedge clk);
    clr = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (5) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    while (done_cnt == 0) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(done_cnt == 1, "R9 extra start done count", done_cnt, 1);
    chk(cmd_cnt == 1, "R9 extra start commands", cmd_cnt, 1);
    chk(tf_cs == 0, "R10 bus idle", tf_cs, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule